// File: doc/BRIEF.md
# BCD Timekeeping Register Bank

This block is a byte-wide RAM with a calendar clock placed in its top eight addresses. Everything below those eight locations is ordinary storage. The eight clock locations hold a control byte and seven packed-BCD time fields: seconds, minutes, hours, day of week, date, month and two-digit year. A 1 Hz tick advances the live counters. The chip-enable and write-enable bus is active-low and synchronous. Reads return data one cycle later.

Software never sees the live counters directly. It sees a copy that follows them on every cycle unless one of two hold bits in the control byte is set:
- The read hold bit freezes the copy so that a multi-byte read is consistent.
- The write hold bit lets software stage a new time. Clearing it loads the staged time into the counters.

Bits that no time field uses behave as plain RAM bits. A power-fail input blocks every access and holds a reset output low. Setting a test bit makes a square wave that follows the tick.

Top module: `bcd_clock_ram`

## Requirements
- R1: An access to an address below the top eight locations reaches plain RAM of 2^RAM_AW bytes. Only the low RAM_AW address bits select the byte. A written byte reads back unchanged.
- R2: A read is sampled at a clock edge where ce_n=0 and we_n=1, and its data appears on rdata after that edge. rdata keeps its value through writes and idle cycles. It is 0 after reset.
- R3: Every tick advances seconds by one in BCD. The carries run seconds 59→00, minutes 59→00, hours 23→00. The hour carry moves day of week (07→01) and date. Reset time is 00:00:00, day 01, date 01, month 01, year 00.
- R4: Date rolls to 01 after the last day of the month, and that carries into month (12→01) and year (99→00). The month lengths are 30 days for months 04, 06, 09 and 11, 31 days for the other months except February, and 29 days for February when the year is divisible by 4, otherwise 28.
- R5: While bit 7 of the seconds byte (offset 1) is 1, ticks do not advance the time.
- R6: Bits outside the time fields read back what was last written. Field widths are 7 bits for seconds and minutes, 6 for hours and date, 3 for day, 5 for month and 8 for year. Control byte bits 5:0 and day bit 6 are also stored bits.
- R7: While control bit 6 is 1, the visible time bytes hold still as ticks arrive. After it clears, they show the live time including those ticks.
- R8: While control bit 7 is 1, time-field writes are kept in the visible copy. Writing control bit 7 from 1 to 0 loads them into the counters. With both hold bits clear, a time-field write is replaced by the live value on the next cycle.
- R9: While pwr_fail is 1, no read or write takes effect. rst_n_out is 0 during reset and for each cycle after pwr_fail is sampled high, and 1 otherwise.
- R10: While day bit 6 is 1, ftest_out toggles once every FT_DIV ticks. It goes low on the cycle after the bit clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| pwr_fail | input | 1 | Supply below the write-protect level |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address; offsets 0..7 of the top eight locations are control, seconds, minutes, hours, day, date, month, year |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, one cycle after the read |
| rst_n_out | output | 1 | Active-low reset, low while power has failed |
| ftest_out | output | 1 | Tick-derived test square wave |

## Verification
- **Tick to visible time:** a tick changes the live counters at the edge that samples it. The visible copy follows one edge later, and a read issued after that returns the new value one edge later again.
- **Hold bits and power-fail:** writing a hold bit clear loads the counters at that edge. The copy refreshes on the next edge. rst_n_out and the test output react one edge after their cause.
- **How the bench samples:** every input is driven on the falling edge and every output is sampled on the falling edge. Each bench task is at least one full clock long, so no check lands before the result is due.
- **What the sweeps cover:** sixty-second sweeps through minute carries, and month-end sweeps over all twelve months in three years. The expected time is computed in binary and converted to BCD in the bench.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;

  typedef struct packed {
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] date;
    logic [7:0] day;
    logic [7:0] hr;
    logic [7:0] mins;
    logic [7:0] sec;
  } rtc_time_t;

  localparam int NSLOT = 8;

  localparam rtc_time_t TIME_RESET = '{yr: 8'h00, mon: 8'h01, date: 8'h01, day: 8'h01,
                                       hr: 8'h00, mins: 8'h00, sec: 8'h00};

  // bits of each byte that belong to a counter; the rest are storage
  function automatic logic [7:0] field_mask(input int slot);
    case (slot)
      1, 2:    return 8'h7F;
      3, 5:    return 8'h3F;
      4:       return 8'h07;
      6:       return 8'h1F;
      7:       return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] slot_byte(input rtc_time_t t, input int slot);
    case (slot)
      1:       return t.sec;
      2:       return t.mins;
      3:       return t.hr;
      4:       return t.day;
      5:       return t.date;
      6:       return t.mon;
      7:       return t.yr;
      default: return 8'h00;
    endcase
  endfunction

  // BCD increment with wrap from top to bottom
  function automatic logic [7:0] bcd_step(input logic [7:0] v, input logic [7:0] top,
                                          input logic [7:0] bottom);
    if (v >= top)           return bottom;
    else if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
    else                    return v + 8'd1;
  endfunction

  function automatic logic leap_year(input logic [7:0] y);
    logic [7:0] b;
    b = ({4'd0, y[7:4]} * 8'd10) + {4'd0, y[3:0]};
    return b[1:0] == 2'b00;
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
    case (m)
      8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_ram.sv
`timescale 1ns/1ps
module rtc_ram #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] a,
  input  logic [7:0]    wd,
  output logic [7:0]    q
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[a] <= wd;
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= 8'h00;
    else if (re) q <= mem[a];
  end
endmodule

// File: rtl/rtc_time_core.sv
`timescale 1ns/1ps
module rtc_time_core
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      stop,
  input  logic      load,
  input  rtc_time_t load_val,
  output rtc_time_t now
);
  rtc_time_t  nxt;
  logic [7:0] dlast;
  logic       c_sec, c_min, c_hr, c_date, c_mon;

  always_comb begin
    nxt    = now;
    dlast  = month_last(now.mon, now.yr);
    c_sec  = now.sec  >= 8'h59;
    c_min  = now.mins >= 8'h59;
    c_hr   = now.hr   >= 8'h23;
    c_date = now.date >= dlast;
    c_mon  = now.mon  >= 8'h12;
    nxt.sec = bcd_step(now.sec, 8'h59, 8'h00);
    if (c_sec) begin
      nxt.mins = bcd_step(now.mins, 8'h59, 8'h00);
      if (c_min) begin
        nxt.hr = bcd_step(now.hr, 8'h23, 8'h00);
        if (c_hr) begin
          nxt.day  = bcd_step(now.day, 8'h07, 8'h01);
          nxt.date = bcd_step(now.date, dlast, 8'h01);
          if (c_date) begin
            nxt.mon = bcd_step(now.mon, 8'h12, 8'h01);
            if (c_mon) nxt.yr = bcd_step(now.yr, 8'h99, 8'h00);
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)               now <= TIME_RESET;
    else if (load)         now <= load_val;
    else if (tick && !stop) now <= nxt;
  end

  assert_sec_bcd_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && !stop && !load && now.sec[3:0] <= 4'd9 && now.sec <= 8'h59)
      |=> (now.sec[3:0] <= 4'd9 && now.sec <= 8'h59));

  assert_day_range_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && !stop && !load && now.day >= 8'h01 && now.day <= 8'h07)
      |=> (now.day >= 8'h01 && now.day <= 8'h07));

  assert_date_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && !stop && !load && now.date != 8'h00) |=> (now.date != 8'h00));

  assert_stop_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (tick && stop && !load) |=> $stable(now));
endmodule

// File: rtl/rtc_ftest.sv
`timescale 1ns/1ps
module rtc_ftest #(
  parameter int FT_DIV = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  output logic wave
);
  localparam int CNT_W = (FT_DIV > 1) ? $clog2(FT_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(FT_DIV - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      wave <= 1'b0;
    end else if (tick) begin
      if (cnt == CNT_TOP) begin
        cnt  <= '0;
        wave <= ~wave;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_ft_off_R10: assert property (@(posedge clk) disable iff (rst)
    !en |=> !wave);
endmodule

// File: rtl/bcd_clock_ram.sv
`timescale 1ns/1ps
module bcd_clock_ram
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int RAM_AW = 10,
  parameter int FT_DIV = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic              pwr_fail,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              rst_n_out,
  output logic              ftest_out
);
  localparam int SLOT_W = $clog2(NSLOT);

  // access decode
  logic              acc, do_wr, do_rd, is_clk, clk_wr, clk_rd;
  logic [SLOT_W-1:0] slot;

  assign acc    = !ce_n && !pwr_fail;
  assign do_wr  = acc && !we_n;
  assign do_rd  = acc && we_n;
  assign is_clk = &addr[ADDR_W-1:SLOT_W];
  assign slot   = addr[SLOT_W-1:0];
  assign clk_wr = do_wr && is_clk;
  assign clk_rd = do_rd && is_clk;

  // plain RAM
  logic [7:0] ram_q;

  rtc_ram #(.AW(RAM_AW)) u_ram (
    .clk (clk),
    .rst (rst),
    .we  (do_wr && !is_clk),
    .re  (do_rd && !is_clk),
    .a   (addr[RAM_AW-1:0]),
    .wd  (wdata),
    .q   (ram_q)
  );

  // live counters
  rtc_time_t  live, load_val;
  logic [7:0] cp_q [NSLOT];
  logic [7:0] live_b [NSLOT];
  logic       hold_rd, hold_wr, refresh, load, stop;

  assign hold_rd = cp_q[0][6];
  assign hold_wr = cp_q[0][7];
  assign refresh = !hold_rd && !hold_wr;
  assign load    = clk_wr && (slot == SLOT_W'(0)) && hold_wr && !wdata[7];
  assign stop    = cp_q[1][7];

  always_comb begin
    load_val.sec  = cp_q[1] & field_mask(1);
    load_val.mins = cp_q[2] & field_mask(2);
    load_val.hr   = cp_q[3] & field_mask(3);
    load_val.day  = cp_q[4] & field_mask(4);
    load_val.date = cp_q[5] & field_mask(5);
    load_val.mon  = cp_q[6] & field_mask(6);
    load_val.yr   = cp_q[7] & field_mask(7);
  end

  rtc_time_core u_core (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick_1hz),
    .stop     (stop),
    .load     (load),
    .load_val (load_val),
    .now      (live)
  );

  // visible copy: counter bits follow live time unless held, spare bits store
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign live_b[g] = slot_byte(live, g);

    always_ff @(posedge clk) begin
      if (rst)
        cp_q[g] <= slot_byte(TIME_RESET, g);
      else if (clk_wr && slot == SLOT_W'(g))
        cp_q[g] <= wdata;
      else if (g != 0 && refresh)
        cp_q[g] <= (cp_q[g] & ~field_mask(g)) | (live_b[g] & field_mask(g));
    end
  end

  // read path
  logic [7:0] clk_rd_q;
  logic       sel_clk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_rd_q  <= 8'h00;
      sel_clk_q <= 1'b0;
    end else if (do_rd) begin
      sel_clk_q <= is_clk;
      if (is_clk) clk_rd_q <= cp_q[slot];
    end
  end

  assign rdata = sel_clk_q ? clk_rd_q : ram_q;

  // power-fail reset output
  always_ff @(posedge clk) begin
    if (rst) rst_n_out <= 1'b0;
    else     rst_n_out <= !pwr_fail;
  end

  rtc_ftest #(.FT_DIV(FT_DIV)) u_ft (
    .clk  (clk),
    .rst  (rst),
    .en   (cp_q[4][6]),
    .tick (tick_1hz),
    .wave (ftest_out)
  );

  assert_pf_no_read_R9: assert property (@(posedge clk) disable iff (rst)
    pwr_fail |=> $stable(rdata));

  assert_pf_rstn_R9: assert property (@(posedge clk) disable iff (rst)
    pwr_fail |=> !rst_n_out);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> $stable(rdata));

  assert_rd_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    (hold_rd && !(clk_wr && slot == SLOT_W'(1))) |=> $stable(cp_q[1]));
endmodule

// File: tb/sim_bcd_clock_ram.sv
`timescale 1ns/1ps
module sim_bcd_clock_ram;
  localparam int AW  = 13;
  localparam int RAW = 6;
  localparam int FTD = 2;
  localparam logic [12:0] A_CTL = 13'h1FF8, A_SEC = 13'h1FF9, A_MIN = 13'h1FFA,
                          A_HR  = 13'h1FFB, A_DAY = 13'h1FFC, A_DATE = 13'h1FFD,
                          A_MON = 13'h1FFE, A_YR  = 13'h1FFF;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, tick = 1'b0, pf = 1'b0, ce_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] wdata = 8'h00, rdata;
  logic rst_n_out, ftest_out;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  bcd_clock_ram #(.ADDR_W(AW), .RAM_AW(RAW), .FT_DIV(FTD)) u0 (
    .clk(clk), .rst(rst), .tick_1hz(tick), .pwr_fail(pf), .ce_n(ce_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rst_n_out(rst_n_out), .ftest_out(ftest_out));

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; addr = a; wdata = d;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd(input logic [12:0] a, output logic [7:0] d);
    @(negedge clk); ce_n = 1'b0; we_n = 1'b1; addr = a;
    @(negedge clk); d = rdata; ce_n = 1'b1;
  endtask

  task automatic tick1();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] s, m, h, dw, dt, mo, y);
    wr(A_CTL, 8'h80);
    wr(A_SEC, s); wr(A_MIN, m); wr(A_HR, h); wr(A_DAY, dw);
    wr(A_DATE, dt); wr(A_MON, mo); wr(A_YR, y);
    wr(A_CTL, 8'h00);
  endtask

  function automatic logic [7:0] tobcd(input int x);
    return 8'((x / 10) * 16 + (x % 10));
  endfunction

  function automatic int days_in(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 5) % 256);
  endfunction

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v, held;
    int total;

    // reset state
    repeat (3) @(negedge clk);
    chk("R9 rst_n_out in reset", {7'd0, rst_n_out}, 8'h00);
    chk("R10 ftest_out in reset", {7'd0, ftest_out}, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 rdata after reset", rdata, 8'h00);
    chk("R9 rst_n_out after reset", {7'd0, rst_n_out}, 8'h01);
    rd(A_SEC, v);  chk("R3 reset seconds", v, 8'h00);
    rd(A_DAY, v);  chk("R3 reset day", v, 8'h01);
    rd(A_MON, v);  chk("R3 reset month", v, 8'h01);

    // R1: full sweep of the small RAM, then aliasing of upper address bits
    for (int i = 0; i < (1 << RAW); i++) wr(13'(i), pat(i));
    for (int i = 0; i < (1 << RAW); i++) begin
      rd(13'(i), v); chk("R1 ram sweep", v, pat(i));
    end
    rd(13'h0405, v); chk("R1 upper bits ignored", v, pat(5));
    rd(13'h1FF7, v); chk("R1 just below clock", v, pat(55));

    // R2: rdata holds across writes and idle cycles
    wr(13'h0003, 8'h00);
    chk("R2 hold over write", rdata, pat(55));
    repeat (3) @(negedge clk);
    chk("R2 hold idle", rdata, pat(55));

    // R9: power fail blocks access
    @(negedge clk); pf = 1'b1;
    @(negedge clk);
    chk("R9 rst_n_out low", {7'd0, rst_n_out}, 8'h00);
    held = rdata;
    wr(13'h0005, 8'hEE);
    wr(A_CTL, 8'h3F);
    rd(13'h0009, v); chk("R9 read blocked", v, held);
    @(negedge clk); pf = 1'b0;
    @(negedge clk);
    chk("R9 rst_n_out high", {7'd0, rst_n_out}, 8'h01);
    rd(13'h0005, v); chk("R9 write blocked", v, pat(5));
    rd(A_CTL, v);    chk("R9 clock write blocked", v, 8'h00);

    // R3: minute and hour carries over a sweep of ticks
    set_time(8'h00, 8'h58, 8'h00, 8'h03, 8'h10, 8'h05, 8'h21);
    total = 58 * 60;
    for (int k = 0; k < 130; k++) begin
      tick1();
      total++;
      rd(A_SEC, v); chk("R3 sweep seconds", v, tobcd(total % 60));
      rd(A_MIN, v); chk("R3 sweep minutes", v, tobcd((total / 60) % 60));
      rd(A_HR, v);  chk("R3 sweep hours", v, tobcd(total / 3600));
    end

    // R4: end-of-month rollover, all months, three years
    for (int yi = 0; yi < 3; yi++) begin
      for (int m = 1; m <= 12; m++) begin
        int y, dw, edw, em, ey;
        y   = (yi == 0) ? 23 : ((yi == 1) ? 24 : 99);
        dw  = (m % 7) + 1;
        edw = (dw == 7) ? 1 : dw + 1;
        em  = (m == 12) ? 1 : m + 1;
        ey  = (m == 12) ? (y + 1) % 100 : y;
        set_time(8'h59, 8'h59, 8'h23, tobcd(dw), tobcd(days_in(m, y)), tobcd(m), tobcd(y));
        tick1();
        rd(A_SEC, v);  chk("R3 rollover seconds", v, 8'h00);
        rd(A_MIN, v);  chk("R3 rollover minutes", v, 8'h00);
        rd(A_HR, v);   chk("R3 rollover hours", v, 8'h00);
        rd(A_DAY, v);  chk("R3 day of week wrap", v, tobcd(edw));
        rd(A_DATE, v); chk("R4 date to 01", v, 8'h01);
        rd(A_MON, v);  chk("R4 month carry", v, tobcd(em));
        rd(A_YR, v);   chk("R4 year carry", v, tobcd(ey));
      end
    end
    set_time(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, 8'h24);
    tick1();
    rd(A_DATE, v); chk("R4 leap Feb 28 to 29", v, 8'h29);
    rd(A_MON, v);  chk("R4 leap stays Feb", v, 8'h02);

    // R5: stop bit
    set_time(8'hA0, 8'h00, 8'h12, 8'h01, 8'h01, 8'h01, 8'h10);
    tick1(); tick1(); tick1();
    rd(A_SEC, v); chk("R5 stopped", v, 8'hA0);
    wr(A_SEC, 8'h20);
    tick1();
    rd(A_SEC, v); chk("R5 running again", v, 8'h21);

    // R6: spare bits are storage
    set_time(8'h10, 8'h85, 8'hC7, 8'hB9, 8'hC5, 8'hE3, 8'h24);
    rd(A_MIN, v);  chk("R6 minutes spare", v, 8'h85);
    rd(A_HR, v);   chk("R6 hours spare", v, 8'hC7);
    rd(A_DAY, v);  chk("R6 day spare", v, 8'hB9);
    rd(A_DATE, v); chk("R6 date spare", v, 8'hC5);
    rd(A_MON, v);  chk("R6 month spare", v, 8'hE3);
    wr(A_CTL, 8'h3F);
    rd(A_CTL, v);  chk("R6 control spare", v, 8'h3F);
    wr(A_CTL, 8'h00);

    // R7: read hold
    set_time(8'h10, 8'h00, 8'h01, 8'h01, 8'h01, 8'h01, 8'h01);
    wr(A_CTL, 8'h40);
    tick1(); tick1(); tick1();
    rd(A_SEC, v); chk("R7 frozen copy", v, 8'h10);
    wr(A_CTL, 8'h00);
    rd(A_SEC, v); chk("R7 reload after hold", v, 8'h13);

    // R8: write hold and transfer
    wr(A_CTL, 8'h80);
    wr(A_SEC, 8'h45);
    tick1();
    rd(A_SEC, v); chk("R8 staged value held", v, 8'h45);
    wr(A_CTL, 8'h00);
    rd(A_SEC, v); chk("R8 transferred", v, 8'h45);
    tick1();
    rd(A_SEC, v); chk("R8 counts from loaded", v, 8'h46);
    wr(A_SEC, 8'h30);
    rd(A_SEC, v); chk("R8 write without hold replaced", v, 8'h46);

    // R10: test output
    wr(A_DAY, 8'h41);
    chk("R10 starts low", {7'd0, ftest_out}, 8'h00);
    tick1();
    chk("R10 one tick no toggle", {7'd0, ftest_out}, 8'h00);
    tick1();
    chk("R10 toggles after two", {7'd0, ftest_out}, 8'h01);
    tick1();
    chk("R10 third tick", {7'd0, ftest_out}, 8'h01);
    tick1();
    chk("R10 toggles back", {7'd0, ftest_out}, 8'h00);
    tick1(); tick1();
    chk("R10 high again", {7'd0, ftest_out}, 8'h01);
    wr(A_DAY, 8'h01);
    @(negedge clk);
    chk("R10 off when bit cleared", {7'd0, ftest_out}, 8'h00);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule